// File: doc/BRIEF.md
# Page Write Buffer Controller

This block sits behind a two-wire serial bus front end and handles the write side of a small byte-addressed nonvolatile array. The front end tells it when a device address request has been decoded, hands it every following byte with a one-cycle strobe, reports the STOP condition, and pulses a sample strobe at the clock edge where the write-protect pin must be read. The block answers every request and every byte with an accept or reject decision one cycle later. The front end turns that decision into ACK or NoACK.

Within a write transaction, the first byte sets the memory pointer. Each later byte is placed in a page buffer at the pointer's in-page offset, and that offset then advances modulo the page size. Nothing reaches the array until STOP. At STOP the block holds a busy window of fixed length. During that window it commits only the buffer slots that were filled, and it refuses every request. A host can therefore poll with address requests until it gets an acknowledge. A write-protect level latched before the first data byte blocks writes aimed at the upper half of the array.

The array is held inside the block, is erased (all bytes FFh) by reset, and has a combinational read port for the read path and for inspection.

Top module: `pwb_page_writer`

## Requirements
- R1: After reset, busy and rsp_vld are low and every array location reads FFh on rd_data.
- R2: Every addr_req or byte_vld strobe produces rsp_vld high in exactly the next cycle, and no other cycle has rsp_vld high. rsp_ack can be high only together with rsp_vld. An address request is accepted (rsp_ack=1) exactly when busy is low.
- R3: The first byte after an accepted write request (addr_rnw=0) is always accepted. It loads the pointer: the upper 4 bits select the page and the lower 4 bits the start offset. It stores no data.
- R4: Each later accepted data byte goes to buffer offset (start + n) mod 16, where n is its position starting at 0. The page bits never change. When more than 16 bytes arrive, earlier bytes at the same offset are overwritten.
- R5: The array does not change before STOP. When a STOP ends a write with at least one accepted data byte, busy is high from the next cycle for exactly WR_CYCLES cycles. Commit writes (cm_we) occur only while busy is high.
- R6: After the busy window, each offset filled in the transaction holds its last received byte at {page, offset}. Every other location keeps its previous value.
- R7: The write-protect input is latched on the first wp_sample pulse that comes after the pointer byte and before the first data byte. Any later wp_sample pulse in the same transaction has no effect.
- R8: If the latched write-protect value is 1 and pointer bit 7 is 1, the first and all later data bytes are rejected, and STOP writes nothing and leaves busy low. With pointer bit 7 equal to 0, a latched 1 has no effect.
- R9: A STOP that comes before any data byte starts no write cycle and leaves busy low.
- R10: While busy is high, every byte strobe is rejected and STOP is ignored.
- R11: A new address request abandons any buffered, uncommitted bytes. A read request (addr_rnw=1) is accepted when not busy, and the bytes that follow it are rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_req | input | 1 | One-cycle strobe: matching device address decoded |
| addr_rnw | input | 1 | Direction of that request, 1 = read |
| byte_vld | input | 1 | One-cycle strobe: byte_data holds a received byte |
| byte_data | input | DW | Received byte |
| wp_sample | input | 1 | Strobe marking the write-protect sampling edge |
| wp | input | 1 | Write-protect level |
| stop | input | 1 | One-cycle strobe: STOP seen on the bus |
| rsp_vld | output | 1 | Decision valid, one cycle after a strobe |
| rsp_ack | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| busy | output | 1 | Internal write window in progress |
| cm_we | output | 1 | Commit write enable to the array |
| cm_addr | output | MEM_AW | Commit address |
| cm_data | output | DW | Commit data |
| rd_addr | input | MEM_AW | Array read address |
| rd_data | output | DW | Array read data (combinational) |

## Verification
The assertions assume a well-formed front end:
- addr_req, byte_vld, wp_sample and stop are single-cycle pulses, and no two of them are high in the same cycle.
- STOP never coincides with a strobe.

The stimulus keeps to these rules by driving each strobe from a task that raises it for one cycle and clears it before the next strobe is issued. Random transactions vary the pointer, the byte count (zero to beyond one page), the write-protect level and whether it is sampled. Requests sent during the busy window are also spaced one per cycle pair, so they are never simultaneous.

// File: rtl/pwb_pkg.sv
// Package: shared types for the page write buffer controller.
package pwb_pkg;
    // Transaction phase of the write-side control.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,  // no write transaction open
        PH_PTR  = 2'd1,  // next byte is the memory pointer
        PH_DATA = 2'd2,  // bytes are data for the page buffer
        PH_REJ  = 2'd3   // write refused by protection, drop all
    } phase_t;
endpackage

// File: rtl/pwb_page_buf.sv
// Module: pwb_page_buf
// Holds one page of data bytes with a fill flag per slot.
// Assumes clr and wr_en are never high in the same cycle.
module pwb_page_buf #(
    parameter int PAGE_AW = 4,
    parameter int DW      = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               wr_en,
    input  logic [PAGE_AW-1:0] wr_idx,
    input  logic [DW-1:0]      wr_data,
    input  logic [PAGE_AW-1:0] rd_idx,
    output logic [DW-1:0]      rd_data,
    output logic               rd_valid,
    output logic               any_valid
);
    localparam int PAGE = 1 << PAGE_AW;

    logic [PAGE-1:0] vld_w;
    logic [DW-1:0]   dat_w [PAGE];

    for (genvar g = 0; g < PAGE; g++) begin : g_slot
        logic          v_q;
        logic [DW-1:0] d_q;
        // Slot g: capture data on a matching write, drop the flag on clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                d_q <= '0;
            end else if (clr) begin
                v_q <= 1'b0;
            end else if (wr_en && (wr_idx == PAGE_AW'(g))) begin
                v_q <= 1'b1;
                d_q <= wr_data;
            end
        end
        assign vld_w[g] = v_q;
        assign dat_w[g] = d_q;
    end

    // Read side: slot contents and fill flag selected by the sweep index.
    assign rd_data   = dat_w[rd_idx];
    assign rd_valid  = vld_w[rd_idx];
    assign any_valid = |vld_w;
endmodule

// File: rtl/pwb_wr_timer.sv
// Module: pwb_wr_timer
// Busy window generator: a start pulse opens a window of exactly CYCLES
// cycles, and cnt shows the position within it. Starts arriving while
// busy are ignored.
module pwb_wr_timer #(
    parameter int CYCLES = 40
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    output logic                      busy,
    output logic [$clog2(CYCLES)-1:0] cnt
);
    localparam int CW = $clog2(CYCLES);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    // Window sequencing: open on start, close after the last count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (!busy) begin
            busy <= start;
            cnt  <= '0;
        end else if (cnt == LAST) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pwb_array.sv
// Module: pwb_array
// Byte-wide storage array. Reset erases every location to all ones.
// One synchronous write port and one combinational read port.
module pwb_array #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    // Storage update: erase on reset, otherwise a single-byte write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Read port.
    assign rdata = mem_q[raddr];
endmodule

// File: rtl/pwb_page_writer.sv
// Module: pwb_page_writer (top)
// Collects the data bytes of one write transaction into a page buffer and
// commits the filled slots to the array in a fixed busy window after STOP.
// Decides accept/reject for every request and byte, one cycle later.
// Assumes: strobes (addr_req, byte_vld, wp_sample, stop) are single-cycle
// and mutually exclusive; DW >= MEM_AW; WR_CYCLES >= page size.
module pwb_page_writer
    import pwb_pkg::*;
#(
    parameter int MEM_AW    = 8,
    parameter int PAGE_AW   = 4,
    parameter int DW        = 8,
    parameter int WR_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_req,
    input  logic              addr_rnw,
    input  logic              byte_vld,
    input  logic [DW-1:0]     byte_data,
    input  logic              wp_sample,
    input  logic              wp,
    input  logic              stop,
    output logic              rsp_vld,
    output logic              rsp_ack,
    output logic              busy,
    output logic              cm_we,
    output logic [MEM_AW-1:0] cm_addr,
    output logic [DW-1:0]     cm_data,
    input  logic [MEM_AW-1:0] rd_addr,
    output logic [DW-1:0]     rd_data
);
    localparam int PG_W = MEM_AW - PAGE_AW;
    localparam int TCW  = $clog2(WR_CYCLES);

    phase_t             phase_q, phase_d;
    logic [PG_W-1:0]    page_q, page_d;
    logic [PAGE_AW-1:0] off_q, off_d;
    logic               first_q, first_d;
    logic               wp_taken_q, wp_taken_d;
    logic               wp_lat_q, wp_lat_d;
    logic               ack_d;
    logic               buf_clr, buf_wr, start_wr;

    logic [TCW-1:0]     tcnt;
    logic               in_sweep;
    logic [PAGE_AW-1:0] sweep_idx;
    logic [DW-1:0]      slot_data;
    logic               slot_valid, any_filled;

    // Decision logic: next phase, pointer, protection latch and buffer actions.
    always_comb begin
        phase_d    = phase_q;
        page_d     = page_q;
        off_d      = off_q;
        first_d    = first_q;
        wp_taken_d = wp_taken_q;
        wp_lat_d   = wp_lat_q;
        ack_d      = 1'b0;
        buf_clr    = 1'b0;
        buf_wr     = 1'b0;
        start_wr   = 1'b0;
        if (addr_req) begin
            ack_d = !busy;
            if (!busy) begin
                buf_clr    = 1'b1;
                wp_taken_d = 1'b0;
                wp_lat_d   = 1'b0;
                phase_d    = addr_rnw ? PH_IDLE : PH_PTR;
            end
        end else if (byte_vld) begin
            unique case (phase_q)
                PH_PTR: begin
                    ack_d   = 1'b1;
                    page_d  = byte_data[MEM_AW-1:PAGE_AW];
                    off_d   = byte_data[PAGE_AW-1:0];
                    first_d = 1'b1;
                    phase_d = PH_DATA;
                end
                PH_DATA: begin
                    if (first_q && wp_lat_q && page_q[PG_W-1]) begin
                        phase_d = PH_REJ;
                    end else begin
                        ack_d   = 1'b1;
                        buf_wr  = 1'b1;
                        off_d   = off_q + 1'b1;
                        first_d = 1'b0;
                    end
                end
                default: ack_d = 1'b0;
            endcase
        end else if (wp_sample) begin
            if (phase_q == PH_DATA && first_q && !wp_taken_q) begin
                wp_taken_d = 1'b1;
                wp_lat_d   = wp;
            end
        end else if (stop && !busy) begin
            start_wr = (phase_q == PH_DATA) && any_filled;
            phase_d  = PH_IDLE;
        end
    end

    // Control state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            page_q     <= '0;
            off_q      <= '0;
            first_q    <= 1'b0;
            wp_taken_q <= 1'b0;
            wp_lat_q   <= 1'b0;
        end else begin
            phase_q    <= phase_d;
            page_q     <= page_d;
            off_q      <= off_d;
            first_q    <= first_d;
            wp_taken_q <= wp_taken_d;
            wp_lat_q   <= wp_lat_d;
        end
    end

    // Response register: one decision per strobe, the cycle after it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld <= 1'b0;
            rsp_ack <= 1'b0;
        end else begin
            rsp_vld <= addr_req || byte_vld;
            rsp_ack <= ack_d;
        end
    end

    pwb_page_buf #(.PAGE_AW(PAGE_AW), .DW(DW)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (buf_clr),
        .wr_en     (buf_wr),
        .wr_idx    (off_q),
        .wr_data   (byte_data),
        .rd_idx    (sweep_idx),
        .rd_data   (slot_data),
        .rd_valid  (slot_valid),
        .any_valid (any_filled)
    );

    pwb_wr_timer #(.CYCLES(WR_CYCLES)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_wr),
        .busy  (busy),
        .cnt   (tcnt)
    );

    // Commit sweep: the first page-size cycles of the window visit each slot.
    assign sweep_idx = tcnt[PAGE_AW-1:0];
    assign in_sweep  = busy && ((tcnt >> PAGE_AW) == '0);
    assign cm_we     = in_sweep && slot_valid;
    assign cm_addr   = {page_q, sweep_idx};
    assign cm_data   = slot_data;

    pwb_array #(.AW(MEM_AW), .DW(DW)) u_arr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cm_we),
        .waddr (cm_addr),
        .wdata (cm_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );
endmodule

// File: rtl/pwb_checker.sv
// Module: pwb_checker
// Protocol and timing properties of pwb_page_writer, bound to every instance.
// Assumes the front-end strobes are single-cycle and mutually exclusive.
module pwb_checker #(
    parameter int WR_CYCLES = 40
) (
    input logic clk,
    input logic rst_n,
    input logic addr_req,
    input logic byte_vld,
    input logic stop,
    input logic rsp_vld,
    input logic rsp_ack,
    input logic busy,
    input logic cm_we
);
    logic [31:0] run_q;

    // Length of the current busy run, counted in cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else if (busy) run_q <= run_q + 1;
        else run_q <= '0;
    end

    assert_resp_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_req || byte_vld) |=> rsp_vld);
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_req || byte_vld) |=> !rsp_vld);
    assert_ack_qual_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ack |-> rsp_vld);
    assert_busy_nack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (addr_req || byte_vld)) |=> !rsp_ack);
    assert_commit_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cm_we |-> busy);
    assert_busy_after_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop));
    assert_busy_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < 32'(WR_CYCLES)));
    assert_busy_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == 32'(WR_CYCLES)));
endmodule

bind pwb_page_writer pwb_checker #(.WR_CYCLES(WR_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_req (addr_req),
    .byte_vld (byte_vld),
    .stop     (stop),
    .rsp_vld  (rsp_vld),
    .rsp_ack  (rsp_ack),
    .busy     (busy),
    .cm_we    (cm_we)
);

// File: tb/sim_pwb_page_writer.sv
module sim_pwb_page_writer;
    localparam int WR = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_req = 1'b0, addr_rnw = 1'b0, byte_vld = 1'b0;
    logic [7:0] byte_data = '0;
    logic       wp_sample = 1'b0, wp = 1'b0, stop = 1'b0;
    logic       rsp_vld, rsp_ack, busy, cm_we;
    logic [7:0] cm_addr, cm_data, rd_data;
    logic [7:0] rd_addr = '0;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model [256];

    always #5 clk = ~clk;

    pwb_page_writer #(.MEM_AW(8), .PAGE_AW(4), .DW(8), .WR_CYCLES(WR)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_req(addr_req), .addr_rnw(addr_rnw),
        .byte_vld(byte_vld), .byte_data(byte_data), .wp_sample(wp_sample),
        .wp(wp), .stop(stop), .rsp_vld(rsp_vld), .rsp_ack(rsp_ack),
        .busy(busy), .cm_we(cm_we), .cm_addr(cm_addr), .cm_data(cm_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected response of a strobe: valid and the given ack bit.
    function automatic bit rsp_ok(input logic v, input logic a, input bit exp_ack);
        return (v === 1'b1) && (a === exp_ack);
    endfunction

    task automatic check_array(input string req);
        int bad = 0;
        int first = -1;
        for (int a = 0; a < 256; a++) begin
            rd_addr = 8'(a);
            #0.1;
            if (rd_data !== model[a]) begin
                bad++;
                if (first < 0) first = a;
            end
        end
        chk(bad == 0, req, $sformatf("array mismatches (first at %0d)", first), bad, 0);
    endtask

    task automatic send_addr(input bit rnw, input bit exp_ack, input string req);
        @(negedge clk); addr_req = 1'b1; addr_rnw = rnw;
        @(negedge clk); addr_req = 1'b0;
        chk(rsp_ok(rsp_vld, rsp_ack, exp_ack), req, "address response",
            {rsp_vld, rsp_ack}, {1'b1, exp_ack});
    endtask

    task automatic send_byte(input logic [7:0] d, input bit exp_ack, input string req);
        @(negedge clk); byte_vld = 1'b1; byte_data = d;
        @(negedge clk); byte_vld = 1'b0;
        chk(rsp_ok(rsp_vld, rsp_ack, exp_ack), req, "byte response",
            {rsp_vld, rsp_ack}, {1'b1, exp_ack});
    endtask

    task automatic pulse_wp(input bit v);
        @(negedge clk); wp = v; wp_sample = 1'b1;
        @(negedge clk); wp_sample = 1'b0;
    endtask

    // STOP, then either verify no write window or measure it (optionally
    // probing with an address request and a byte while busy).
    task automatic do_stop(input bit exp_busy, input bit probe, input string req);
        int n = 0;
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        if (!exp_busy) begin
            chk(busy === 1'b0, req, "busy after stop", busy, 0);
            repeat (3) @(negedge clk);
            chk(busy === 1'b0, req, "busy later", busy, 0);
            return;
        end
        chk(busy === 1'b1, "R5", "busy right after stop", busy, 1);
        while (busy === 1'b1 && n < WR + 10) begin
            n++;
            if (probe) begin
                if (n == 3) begin
                    addr_req = 1'b0;
                    chk(rsp_ok(rsp_vld, rsp_ack, 1'b0), "R2", "addr while busy",
                        {rsp_vld, rsp_ack}, 2'b10);
                end
                if (n == 5) begin
                    byte_vld = 1'b0;
                    chk(rsp_ok(rsp_vld, rsp_ack, 1'b0), "R10", "byte while busy",
                        {rsp_vld, rsp_ack}, 2'b10);
                end
                if (n == 2) begin addr_req = 1'b1; addr_rnw = 1'b0; end
                if (n == 4) begin byte_vld = 1'b1; byte_data = 8'h5A; end
                if (n == 6) stop = 1'b1;
                if (n == 7) stop = 1'b0;
            end
            @(negedge clk);
        end
        chk(n == WR, "R5", "busy window length", n, WR);
    endtask

    // One write transaction with expectations derived from R3..R9.
    task automatic write_txn(input logic [7:0] ptr, input int nbytes, input bit smp,
                             input bit wpv, input bit late, input bit probe);
        logic [7:0] pend [16];
        bit         pv   [16];
        bit rej, go;
        string dreq;
        for (int i = 0; i < 16; i++) begin pend[i] = '0; pv[i] = 1'b0; end
        send_addr(1'b0, 1'b1, "R2");
        send_byte(ptr, 1'b1, "R3");
        if (smp) pulse_wp(wpv);
        rej  = smp && wpv && ptr[7];
        dreq = rej ? "R8" : "R4";
        for (int i = 0; i < nbytes; i++) begin
            logic [7:0] d = 8'($urandom);
            int off = (int'(ptr[3:0]) + i) % 16;
            send_byte(d, !rej, dreq);
            if (!rej) begin pend[off] = d; pv[off] = 1'b1; end
            if (late && i == 0) pulse_wp(1'b1);
        end
        check_array("R5");
        go = !rej && nbytes > 0;
        do_stop(go, probe, rej ? "R8" : "R9");
        if (go)
            for (int i = 0; i < 16; i++)
                if (pv[i]) model[{ptr[7:4], 4'(i)}] = pend[i];
        check_array(late ? "R7" : rej ? "R8" : nbytes == 0 ? "R9" : "R6");
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        for (int a = 0; a < 256; a++) model[a] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && rsp_vld === 1'b0, "R1", "outputs after reset",
            {busy, rsp_vld}, 0);
        check_array("R1");

        write_txn(8'h23, 3, 1'b0, 1'b0, 1'b0, 1'b0);   // plain, partial page R6
        write_txn(8'h2E, 20, 1'b0, 1'b0, 1'b0, 1'b1);  // wrap + overwrite R4, busy probe R10
        write_txn(8'hA4, 4, 1'b1, 1'b1, 1'b0, 1'b0);   // protected upper half R8
        write_txn(8'h44, 4, 1'b1, 1'b1, 1'b0, 1'b0);   // protection ignored, lower half R8
        write_txn(8'hB0, 2, 1'b1, 1'b0, 1'b1, 1'b0);   // late sample ignored R7
        write_txn(8'hC8, 2, 1'b0, 1'b0, 1'b1, 1'b0);   // sample after data ignored R7
        write_txn(8'h70, 0, 1'b0, 1'b0, 1'b0, 1'b0);   // empty write R9

        // R11: abandon a buffered write with a read request.
        send_addr(1'b0, 1'b1, "R11");
        send_byte(8'h91, 1'b1, "R11");
        send_byte(8'h11, 1'b1, "R11");
        send_byte(8'h22, 1'b1, "R11");
        send_addr(1'b1, 1'b1, "R11");
        send_byte(8'h33, 1'b0, "R11");
        do_stop(1'b0, 1'b0, "R11");
        check_array("R11");

        for (int t = 0; t < 50; t++) begin
            write_txn(8'($urandom), int'($urandom % 21), 1'($urandom), 1'($urandom),
                      1'b0, (t % 10) == 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule